// File: doc/BRIEF.md
# Sync Polarity Step Sequencer

This block sets the horizontal and vertical sync polarity of a downstream device that cannot take a polarity value directly. The device moves through four polarity positions in a fixed cycle. It advances one position for each pulse on a control bit, and it counts that pulse only while a neighbouring enable bit is high. The block records the position the device has reached since reset. From a requested H/V polarity pair it works out how many forward steps are needed. It then drives the device's 8-bit control register through a fixed series of writes, with a settle delay after each write.

A caller presents the wanted polarities together with the current contents of the control register, then raises a one-cycle start strobe. During the sequence the block leaves every register bit except the enable and pulse bits at the value it captured at the start. It holds `busy_o` high while the sequence runs and raises `done_o` for one cycle when the sequence completes. A start strobe that arrives while the block is busy is ignored.

Top module: `sync_pol_stepper`

## Requirements
- R1: Each polarity pair has a target position, with `hpos_i`/`vpos_i` = 1 meaning positive. H+ and V+ gives 0. H− and V+ gives 1. H− and V− gives 2. H+ and V− gives 3.
- R2: The number of pulses in a sequence is (target − tracked position) modulo 4. A negative difference wraps by adding 4.
- R3: The tracked position is 0 after reset. It takes the new target when a sequence is accepted, so the next sequence counts from there.
- R4: The writes come in this order. First, pulse bit (bit 5) cleared with the enable bit (bit 4) unchanged. Second, bit 4 set and bit 5 clear. Then, once per step, bit 5 high and then bit 5 low, with bit 4 high in both. Last, bits 4 and 5 both cleared.
- R5: Consecutive writes in a sequence are exactly SETTLE_CYC + 1 cycles apart, which leaves SETTLE_CYC idle cycles after every write except the last.
- R6: In every write, all bits except 4 and 5 equal `reg_init_i` as sampled at the accepted start. Later changes to `reg_init_i` have no effect on the sequence in progress.
- R7: When the step count is zero, the block still issues the clear, enable and release writes, three writes in total, and issues no pulse.
- R8: A start strobe while `busy_o` is high changes neither the write sequence in progress nor the tracked position.
- R9: After reset, `busy_o`, `done_o` and `wr_en_o` are low. `busy_o` is high from the cycle after an accepted start through the final write. `done_o` is high for exactly the one cycle after the final write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to run a polarity sequence |
| hpos_i | input | 1 | Requested horizontal polarity, 1 = positive |
| vpos_i | input | 1 | Requested vertical polarity, 1 = positive |
| reg_init_i | input | 8 | Current control register contents, sampled at start |
| wr_en_o | output | 1 | Register write strobe |
| wr_data_o | output | 8 | Register write data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse after the final write |

## Verification
The bench models the tracked position on its own and compares the full write log of every sequence against the expected one. It goes after the wrapping step counts, such as a move from position 3 to position 0. A design that did not wrap would issue no pulses or too many, and the device would land on the wrong polarity. It also covers zero-step requests, where a design that skipped the enable or release writes would leave the device with its enable bit set. Mid-sequence starts carry the opposite polarities and an inverted register image. A design that accepted them would restart, lengthen the log or disturb the untouched bits, and the next sequence's pulse count would show that the tracked position had been corrupted.

// File: rtl/spsq_pkg.sv
package spsq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WRITE,
    ST_SETTLE,
    ST_DONE
  } seq_state_t;

  typedef enum logic [2:0] {
    PH_CLR,
    PH_ARM,
    PH_HI,
    PH_LO,
    PH_REL
  } seq_phase_t;

  // Position in the four-step polarity cycle for a polarity pair.
  function automatic logic [1:0] pol_to_pos(input logic h_pos, input logic v_pos);
    logic [1:0] pos;
    case ({h_pos, v_pos})
      2'b11:   pos = 2'd0;
      2'b01:   pos = 2'd1;
      2'b00:   pos = 2'd2;
      default: pos = 2'd3;
    endcase
    return pos;
  endfunction

endpackage

// File: rtl/spsq_step_planner.sv
module spsq_step_planner
  import spsq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept_i,
  input  logic       hpos_i,
  input  logic       vpos_i,
  output logic [1:0] steps_o
);

  logic [1:0] pos_q;
  logic [1:0] pos_d;
  logic [1:0] target;

  always_comb begin
    target  = pol_to_pos(hpos_i, vpos_i);
    // A two-bit difference wraps modulo 4 on its own.
    steps_o = target - pos_q;
    pos_d   = accept_i ? target : pos_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= 2'd0;
    end else if (accept_i) begin
      pos_q <= pos_d;
    end
  end

endmodule

// File: rtl/spsq_settle_timer.sv
module spsq_settle_timer #(
  parameter int SETTLE_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic expired_o
);

  localparam int TW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC + 1);
  localparam logic [TW-1:0] RELOAD = TW'(SETTLE_CYC - 1);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    if (load_i) begin
      cnt_d = RELOAD;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
    expired_o = (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/spsq_word_builder.sv
module spsq_word_builder
  import spsq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int EN_BIT    = 4,
  parameter int PULSE_BIT = 5
) (
  input  seq_phase_t        phase_i,
  input  logic [DATA_W-1:0] base_i,
  output logic [DATA_W-1:0] word_o
);

  logic en_val;
  logic pl_val;

  always_comb begin
    case (phase_i)
      PH_CLR: begin en_val = base_i[EN_BIT]; pl_val = 1'b0; end
      PH_ARM: begin en_val = 1'b1;           pl_val = 1'b0; end
      PH_HI:  begin en_val = 1'b1;           pl_val = 1'b1; end
      PH_LO:  begin en_val = 1'b1;           pl_val = 1'b0; end
      default: begin en_val = 1'b0;          pl_val = 1'b0; end
    endcase
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == EN_BIT) begin : g_en
      assign word_o[i] = en_val;
    end else if (i == PULSE_BIT) begin : g_pl
      assign word_o[i] = pl_val;
    end else begin : g_keep
      assign word_o[i] = base_i[i];
    end
  end

endmodule

// File: rtl/spsq_sequencer.sv
module spsq_sequencer
  import spsq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        steps_i,
  input  logic [DATA_W-1:0] reg_init_i,
  input  logic              expired_i,
  output logic              accept_o,
  output logic              load_o,
  output seq_phase_t        phase_o,
  output logic [DATA_W-1:0] base_o,
  output logic              wr_en_o,
  output logic              busy_o,
  output logic              done_o
);

  seq_state_t        state_q, state_d;
  seq_phase_t        phase_q, phase_d;
  logic [1:0]        left_q, left_d;
  logic [DATA_W-1:0] base_q;
  logic              idle_like;

  always_comb begin
    idle_like = (state_q == ST_IDLE) || (state_q == ST_DONE);
    accept_o  = start_i && idle_like;
    state_d   = state_q;
    phase_d   = phase_q;
    left_d    = left_q;

    case (state_q)
      ST_IDLE, ST_DONE: begin
        if (accept_o) begin
          state_d = ST_WRITE;
          phase_d = PH_CLR;
          left_d  = steps_i;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_WRITE: begin
        if (phase_q == PH_REL) begin
          state_d = ST_DONE;
        end else begin
          state_d = ST_SETTLE;
        end
        if (phase_q == PH_HI) begin
          left_d = left_q - 1'b1;
        end
      end
      ST_SETTLE: begin
        if (expired_i) begin
          state_d = ST_WRITE;
          case (phase_q)
            PH_CLR:        phase_d = PH_ARM;
            PH_ARM, PH_LO: phase_d = (left_q != 2'd0) ? PH_HI : PH_REL;
            PH_HI:         phase_d = PH_LO;
            default:       phase_d = PH_REL;
          endcase
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_CLR;
      left_q  <= 2'd0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      left_q  <= left_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (accept_o) begin
      base_q <= reg_init_i;
    end
  end

  always_comb begin
    load_o  = (state_q == ST_WRITE);
    wr_en_o = (state_q == ST_WRITE);
    busy_o  = (state_q == ST_WRITE) || (state_q == ST_SETTLE);
    done_o  = (state_q == ST_DONE);
    phase_o = phase_q;
    base_o  = base_q;
  end

endmodule

// File: rtl/sync_pol_stepper.sv
module sync_pol_stepper
  import spsq_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int EN_BIT     = 4,
  parameter int PULSE_BIT  = 5,
  parameter int SETTLE_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              hpos_i,
  input  logic              vpos_i,
  input  logic [DATA_W-1:0] reg_init_i,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              busy_o,
  output logic              done_o
);

  logic              accept;
  logic              load;
  logic              expired;
  logic [1:0]        steps;
  seq_phase_t        phase;
  logic [DATA_W-1:0] base;

  spsq_step_planner u_planner (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept),
    .hpos_i   (hpos_i),
    .vpos_i   (vpos_i),
    .steps_o  (steps)
  );

  spsq_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .expired_o (expired)
  );

  spsq_sequencer #(.DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .steps_i    (steps),
    .reg_init_i (reg_init_i),
    .expired_i  (expired),
    .accept_o   (accept),
    .load_o     (load),
    .phase_o    (phase),
    .base_o     (base),
    .wr_en_o    (wr_en_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  spsq_word_builder #(
    .DATA_W   (DATA_W),
    .EN_BIT   (EN_BIT),
    .PULSE_BIT(PULSE_BIT)
  ) u_word (
    .phase_i (phase),
    .base_i  (base),
    .word_o  (wr_data_o)
  );

endmodule

// File: rtl/sync_pol_stepper_chk.sv
module sync_pol_stepper_chk #(
  parameter int DATA_W    = 8,
  parameter int EN_BIT    = 4,
  parameter int PULSE_BIT = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [DATA_W-1:0] reg_init_i,
  input logic              wr_en_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic              busy_o,
  input logic              done_o
);

  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] snap_q;

  always_comb begin
    mask            = '1;
    mask[EN_BIT]    = 1'b0;
    mask[PULSE_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
    end else if (start_i && !busy_o) begin
      snap_q <= reg_init_i;
    end
  end

  // R9
  wr_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> busy_o);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  busy_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R5
  write_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !wr_en_o) |=> busy_o);

  // R4
  pulse_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && wr_data_o[PULSE_BIT]) |-> wr_data_o[EN_BIT]);

  // R6
  keep_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> ((wr_data_o & mask) == (snap_q & mask)));

endmodule

bind sync_pol_stepper sync_pol_stepper_chk #(
  .DATA_W   (DATA_W),
  .EN_BIT   (EN_BIT),
  .PULSE_BIT(PULSE_BIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .reg_init_i (reg_init_i),
  .wr_en_o    (wr_en_o),
  .wr_data_o  (wr_data_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/sync_pol_stepper_bench.sv
`timescale 1ns/1ps
module sync_pol_stepper_bench;

  localparam int S = 3;

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic       hpos_i;
  logic       vpos_i;
  logic [7:0] reg_init_i;
  logic       wr_en_o;
  logic [7:0] wr_data_o;
  logic       busy_o;
  logic       done_o;

  int n_tests;
  int n_fail;
  int cyc;
  int nw;
  int ndone;
  int done_cyc;
  logic [7:0] wlog [0:15];
  int         wcyc [0:15];
  int model_pos;

  sync_pol_stepper #(.SETTLE_CYC(S)) u_sync_pol_stepper (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .hpos_i     (hpos_i),
    .vpos_i     (vpos_i),
    .reg_init_i (reg_init_i),
    .wr_en_o    (wr_en_o),
    .wr_data_o  (wr_data_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (wr_en_o && nw < 16) begin
      wlog[nw] = wr_data_o;
      wcyc[nw] = cyc;
      nw = nw + 1;
    end
    if (done_o) begin
      done_cyc = cyc;
      ndone = ndone + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // R1: target position of a polarity pair
  function automatic int tgt_of(input bit h, input bit v);
    if (h && v) return 0;
    if (!h && v) return 1;
    if (!h && !v) return 2;
    return 3;
  endfunction

  function automatic logic [7:0] exp_word(input logic [7:0] b, input int idx, input int nwr);
    logic [7:0] k;
    k = b & 8'hCF;
    if (idx == 0) return b & 8'hDF;
    if (idx == nwr - 1) return k;
    if (idx == 1) return k | 8'h10;
    if (idx % 2 == 0) return k | 8'h30;
    return k | 8'h10;
  endfunction

  task automatic run_seq(input bit h, input bit v, input logic [7:0] b, input bit disturb);
    int steps;
    int nexp;
    int t;
    int tgt;
    tgt   = tgt_of(h, v);
    steps = (tgt - model_pos + 4) % 4;
    model_pos = tgt;
    nexp  = 3 + 2 * steps;
    @(negedge clk);
    nw = 0; ndone = 0;
    hpos_i = h; vpos_i = v; reg_init_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R9 busy after start", int'(busy_o), 1);
    if (disturb) begin
      repeat (4) @(negedge clk);
      hpos_i = ~h; vpos_i = ~v; reg_init_i = ~b; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    t = 0;
    while (ndone == 0 && t < 200) begin
      @(negedge clk);
      t++;
    end
    chk(ndone == 1, "R9 done seen", ndone, 1);
    // R2 R7 R8: write count follows modulo-4 step count
    chk(nw == nexp, "R2 write count", nw, nexp);
    if (nw == nexp) begin
      for (int i = 0; i < nexp; i++) begin
        logic [7:0] e;
        e = exp_word(b, i, nexp);
        chk(wlog[i] == e, "R4/R6 write word", int'(wlog[i]), int'(e));
        if (i > 0)
          chk(wcyc[i] - wcyc[i-1] == S + 1, "R5 write spacing",
              wcyc[i] - wcyc[i-1], S + 1);
      end
      chk(done_cyc == wcyc[nexp-1] + 1, "R9 done timing", done_cyc, wcyc[nexp-1] + 1);
    end
    chk(busy_o == 1'b0, "R9 busy low after done", int'(busy_o), 0);
    @(negedge clk);
    chk(done_o == 1'b0, "R9 done one cycle", int'(done_o), 0);
  endtask

  initial begin
    n_tests = 0; n_fail = 0; cyc = 0; nw = 0; ndone = 0; done_cyc = 0;
    model_pos = 0;
    start_i = 0; hpos_i = 0; vpos_i = 0; reg_init_i = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0, "R9 reset busy", int'(busy_o), 0);
    chk(done_o == 1'b0, "R9 reset done", int'(done_o), 0);
    chk(wr_en_o == 1'b0, "R9 reset wr_en", int'(wr_en_o), 0);
    rst_n = 1'b1;
    // R3: from reset position 0, H-/V- needs two pulses
    run_seq(1'b0, 1'b0, 8'hFF, 1'b0);
    // R7: same request again, zero steps
    run_seq(1'b0, 1'b0, 8'h5A, 1'b0);
    // R1: H+/V- position 3
    run_seq(1'b1, 1'b0, 8'h01, 1'b0);
    // R2: wrap 3 -> 0
    run_seq(1'b1, 1'b1, 8'hC3, 1'b0);
    // R1: H-/V+ position 1
    run_seq(1'b0, 1'b1, 8'h10, 1'b0);
    // R8 R6: start ignored mid-sequence, changed reg_init ignored
    run_seq(1'b1, 1'b0, 8'hA5, 1'b1);
    run_seq(1'b1, 1'b1, 8'h3C, 1'b0);
    begin
      int seed_v;
      seed_v = $urandom(32'd4242);
      for (int k = 0; k < 40; k++) begin
        logic [7:0] rb;
        int r;
        r  = $urandom;
        rb = 8'($urandom);
        run_seq(r[0], r[1], rb, r[2]);
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=0x1 expected=0x0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule